// File: doc/BRIEF.md
# IDE Strobe Cycle Timing Generator

This block shapes the read or write strobe of one parallel ATA transfer cycle in PIO or multiword DMA mode. A start pulse launches a cycle. The block picks one of two shared 8-bit timing bytes, one for PIO and one for multiword DMA. The upper nibble of that byte sets how long the strobe stays asserted. The lower nibble sets how long the bus then rests before the cycle ends. Both counts are in units of two reference-clock periods. A per-device select bit decides whether the reference is the slow (50 MHz) or the fast (66 MHz) clock.

The block runs on the system clock. It receives each reference clock as a one-cycle tick input, one tick for each reference period. At start it latches the chosen timing byte, the direction and the clock choice of the addressed device. It then drives the matching strobe, holds busy through the recovery period, and ends with a one-cycle done pulse.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset, both strobes, busy and done are low.
- R2: The strobe stays asserted for exactly (A+1)×2 ticks of the selected reference, where A is bits 7:4 of the latched timing byte. A = 0 gives 2 ticks and A = 15 gives 32 ticks.
- R3: After the strobe drops, busy stays high with both strobes low for exactly (R+1)×2 ticks of the selected reference, where R is bits 3:0 of the latched timing byte.
- R4: Bit 0 of `clk_sel` picks the reference for device 0 and bit 1 picks it for device 1. A value of 0 selects `ref_tick_slow` and 1 selects `ref_tick_fast`. Ticks of the reference that is not selected have no effect on the cycle.
- R5: With `xfer_dma` = 0 the cycle uses `pio_timing`, and with `xfer_dma` = 1 it uses `dma_timing`. The same two bytes serve both devices.
- R6: With `dir_wr` = 1 only `strobe_wr` is asserted, and with `dir_wr` = 0 only `strobe_rd` is asserted. The two strobes are never high together.
- R7: `done` is a one-cycle pulse in the first cycle after recovery ends. In that cycle busy is low, and the pulse appears exactly once per accepted start.
- R8: A start pulse that arrives while busy is high, in either the active or the recovery phase, is ignored. It neither extends the cycle nor adds a done pulse.
- R9: The timing byte, direction and clock choice are captured at start. Changes to them during a cycle do not alter that cycle.
- R10: An accepted start raises busy and the selected strobe in the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick_slow | input | 1 | One pulse per slow (50 MHz) reference period |
| ref_tick_fast | input | 1 | One pulse per fast (66 MHz) reference period |
| start | input | 1 | Launch one transfer cycle when idle |
| dir_wr | input | 1 | 1 = write strobe, 0 = read strobe |
| dev_sel | input | 1 | Addressed device (0 or 1) |
| xfer_dma | input | 1 | 0 = PIO timing byte, 1 = multiword DMA timing byte |
| pio_timing | input | 8 | Shared PIO timing: [7:4] active, [3:0] recovery |
| dma_timing | input | 8 | Shared DMA timing: [7:4] active, [3:0] recovery |
| clk_sel | input | 2 | Per-device reference choice, 1 = fast |
| strobe_rd | output | 1 | Read strobe |
| strobe_wr | output | 1 | Write strobe |
| busy | output | 1 | Cycle in progress (active or recovery) |
| done | output | 1 | One-cycle end-of-cycle pulse |

## Verification
The hardest case to reach from the ports is a cycle whose inputs are disturbed while it is running. This covers a second start, a flipped direction, a new timing byte and a swapped clock choice, each arriving once during the active phase and once during the recovery phase. The stimulus task can pulse start again and rewrite every input after a few cycles, or wait until busy is high with both strobes low. The scoreboard still expects only the widths of the original byte, a single done pulse and the original strobe line. The two tick streams run at unrelated rates, so counting in the wrong reference shows up as a width mismatch.

// File: rtl/ide_strobe_pkg.sv
package ide_strobe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_RECOV  = 2'd2
    } phase_e;

endpackage

// File: rtl/ide_strobe_ref_sel.sv
module ide_strobe_ref_sel #(
    parameter int N_DEV = 2,
    localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             ref_tick_slow,
    input  logic             ref_tick_fast,
    input  logic [N_DEV-1:0] clk_sel,
    input  logic [DEV_W-1:0] dev_sel,
    input  logic             fast_lat,
    output logic             fast_now,
    output logic             tick
);
    logic [N_DEV-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N_DEV; g++) begin : g_dev
            assign hit[g] = clk_sel[g] && (dev_sel == DEV_W'(g));
        end
    endgenerate

    assign fast_now = |hit;
    assign tick     = fast_lat ? ref_tick_fast : ref_tick_slow;
endmodule

// File: rtl/ide_strobe_unit_ctr.sv
module ide_strobe_unit_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    assign last = tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer #(
    parameter int NIB_W    = 4,
    parameter int UNIT_REF = 2,
    parameter int N_DEV    = 2,
    localparam int BYTE_W  = 2 * NIB_W,
    localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int CNT_W   = $clog2((2 ** NIB_W) * UNIT_REF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_slow,
    input  logic              ref_tick_fast,
    input  logic              start,
    input  logic              dir_wr,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic              xfer_dma,
    input  logic [BYTE_W-1:0] pio_timing,
    input  logic [BYTE_W-1:0] dma_timing,
    input  logic [N_DEV-1:0]  clk_sel,
    output logic              strobe_rd,
    output logic              strobe_wr,
    output logic              busy,
    output logic              done
);
    import ide_strobe_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic             wr;
        logic             fast;
        logic [NIB_W-1:0] rec;
        logic             done;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              fast_now, tick, last, load;
    logic [CNT_W-1:0]  load_val;
    logic [BYTE_W-1:0] sel_byte;

    function automatic logic [CNT_W-1:0] to_units(input logic [NIB_W-1:0] n);
        return CNT_W'((int'(n) + 1) * UNIT_REF);
    endfunction

    ide_strobe_ref_sel #(.N_DEV(N_DEV)) u_ref (
        .ref_tick_slow (ref_tick_slow),
        .ref_tick_fast (ref_tick_fast),
        .clk_sel       (clk_sel),
        .dev_sel       (dev_sel),
        .fast_lat      (st_q.fast),
        .fast_now      (fast_now),
        .tick          (tick)
    );

    ide_strobe_unit_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick),
        .last     (last)
    );

    assign sel_byte = xfer_dma ? dma_timing : pio_timing;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        load_val  = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.wr    = dir_wr;
                    st_d.fast  = fast_now;
                    st_d.rec   = sel_byte[NIB_W-1:0];
                    load       = 1'b1;
                    load_val   = to_units(sel_byte[BYTE_W-1:NIB_W]);
                end
            end
            PH_ACTIVE: begin
                if (last) begin
                    st_d.phase = PH_RECOV;
                    load       = 1'b1;
                    load_val   = to_units(st_q.rec);
                end
            end
            PH_RECOV: begin
                if (last) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.wr    <= 1'b0;
            st_q.fast  <= 1'b0;
            st_q.rec   <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_rd = (st_q.phase == PH_ACTIVE) && !st_q.wr;
    assign strobe_wr = (st_q.phase == PH_ACTIVE) &&  st_q.wr;
    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = st_q.done;
endmodule

// File: rtl/ide_strobe_timer_chk.sv
module ide_strobe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic strobe_rd,
    input logic strobe_wr,
    input logic busy,
    input logic done
);
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_rd && strobe_wr));

    a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_rd || strobe_wr) |-> busy);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && (strobe_rd || strobe_wr)));

    a_r9_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobe_rd || strobe_wr) && $past(strobe_rd || strobe_wr))
            |-> ($stable(strobe_wr) && $stable(strobe_rd)));
endmodule

bind ide_strobe_timer ide_strobe_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .strobe_rd (strobe_rd),
    .strobe_wr (strobe_wr),
    .busy      (busy),
    .done      (done)
);

// File: tb/ide_strobe_timer_test.sv
module ide_strobe_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick_slow = 1'b0, ref_tick_fast = 1'b0;
    logic start = 1'b0, dir_wr = 1'b0, dev_sel = 1'b0, xfer_dma = 1'b0;
    logic [7:0] pio_timing = '0, dma_timing = '0;
    logic [1:0] clk_sel = '0;
    logic strobe_rd, strobe_wr, busy, done;

    int n_chk = 0, n_fail = 0;

    typedef struct {
        logic wr;
        logic fast;
        int   act;
        int   rec;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    ide_strobe_timer uut (
        .clk(clk), .rst_n(rst_n),
        .ref_tick_slow(ref_tick_slow), .ref_tick_fast(ref_tick_fast),
        .start(start), .dir_wr(dir_wr), .dev_sel(dev_sel), .xfer_dma(xfer_dma),
        .pio_timing(pio_timing), .dma_timing(dma_timing), .clk_sel(clk_sel),
        .strobe_rd(strobe_rd), .strobe_wr(strobe_wr), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // tick generators: slow every 5 clocks, fast every 3 clocks, changed just after posedge
    initial begin
        int cs = 0;
        int cf = 0;
        forever begin
            @(posedge clk);
            #1;
            cs = (cs + 1) % 5;
            cf = (cf + 1) % 3;
            ref_tick_slow = (cs == 0);
            ref_tick_fast = (cf == 0);
        end
    end

    // monitor: counts selected ticks per phase, compares at done
    initial begin
        int as_n = 0, af_n = 0, rs_n = 0, rf_n = 0;
        bit saw_wr = 0, saw_rd = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (strobe_rd || strobe_wr) begin
                if (ref_tick_slow) as_n++;
                if (ref_tick_fast) af_n++;
                if (strobe_wr) saw_wr = 1;
                if (strobe_rd) saw_rd = 1;
            end else if (busy) begin
                if (ref_tick_slow) rs_n++;
                if (ref_tick_fast) rf_n++;
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 extra done", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check((it.fast ? af_n : as_n) == it.act, "R2/R4 active width",
                          it.fast ? af_n : as_n, it.act);
                    check((it.fast ? rf_n : rs_n) == it.rec, "R3/R4 recovery width",
                          it.fast ? rf_n : rs_n, it.rec);
                    check(saw_wr == it.wr && saw_rd == !it.wr, "R6 strobe line",
                          {saw_wr, saw_rd}, it.wr ? 2 : 1);
                    check(!busy && !strobe_rd && !strobe_wr, "R7 idle at done",
                          {busy, strobe_rd, strobe_wr}, 0);
                end
                as_n = 0; af_n = 0; rs_n = 0; rf_n = 0;
                saw_wr = 0; saw_rd = 0;
            end
        end
    end

    // driver: disturb 0 none, 1 during active, 2 during recovery
    task automatic run_xfer(input logic dev, input logic dma, input logic wr,
                            input logic [7:0] pio, input logic [7:0] dmab,
                            input logic [1:0] sel, input int disturb);
        item_t it;
        logic [7:0] b;
        b = dma ? dmab : pio;
        it.wr   = wr;
        it.fast = sel[dev];
        it.act  = (int'(b[7:4]) + 1) * 2;
        it.rec  = (int'(b[3:0]) + 1) * 2;
        exp_q.push_back(it);
        @(negedge clk);
        dev_sel = dev; xfer_dma = dma; dir_wr = wr;
        pio_timing = pio; dma_timing = dmab; clk_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && (wr ? strobe_wr : strobe_rd), "R10 launch next cycle", busy, 1);
        if (disturb == 1) begin
            @(negedge clk);
        end else if (disturb == 2) begin
            while (!(busy && !strobe_rd && !strobe_wr)) @(negedge clk);
        end
        if (disturb != 0) begin
            // R8 / R9: restart attempt with every input changed
            dir_wr = !wr; clk_sel = ~sel; xfer_dma = !dma;
            pio_timing = ~pio; dma_timing = ~dmab;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                check(0, "watchdog", 0, 1);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        check(!strobe_rd && !strobe_wr && !busy && !done, "R1 reset state",
              {strobe_rd, strobe_wr, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        run_xfer(0, 0, 0, 8'hAA, 8'h11, 2'b00, 0); // R2 slow PIO mode 0
        run_xfer(0, 0, 1, 8'h31, 8'hFF, 2'b01, 0); // R4 fast dev0, PIO mode 4
        run_xfer(1, 1, 0, 8'h55, 8'h88, 2'b10, 0); // R5 DMA byte, dev1 fast
        run_xfer(1, 1, 1, 8'h00, 8'h31, 2'b01, 0); // R4 dev1 slow though bit0 set
        run_xfer(0, 0, 0, 8'h00, 8'hFF, 2'b11, 0); // R2 R3 zero counts
        run_xfer(1, 0, 1, 8'hFF, 8'h00, 2'b00, 0); // R2 R3 maximum counts
        run_xfer(0, 0, 0, 8'h23, 8'h44, 2'b00, 1); // R8 R9 disturb in active
        run_xfer(1, 1, 1, 8'h67, 8'h05, 2'b10, 2); // R8 R9 disturb in recovery
        run_xfer(0, 1, 0, 8'h12, 8'h32, 2'b01, 0); // R5 DMA 66 mode 1 style

        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R7 one done per start", exp_q.size(), 0);
        check(!busy && !done, "R8 no late restart", {busy, done}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule